// File: doc/BRIEF.md
# Keyed Access Lock Controller

This block is the decision logic of a door lock that reads contactless keys. An upstream decoder presents each recognized key as a one-cycle strobe with an identifier word. The block looks that word up in a small on-chip table of enrolled keys. A match releases the lock and lights the LED. The door stays released while the key remains in the field, and for a fixed hold time after it is withdrawn. All timing comes from a one-millisecond tick input.

A learn button puts the block into an enrolment window. The LED blinks slowly while the window is open. The next recognized key is written into the table slot chosen by a selector switch, unless that key is already enrolled in a different slot. The window closes on that key or when its time runs out.

The open hold and the enrolment window never run at the same time. Because of this, a single countdown counter serves both of them.

Top module: `keylock_ctrl`

## Requirements
- R1: After reset the lock is engaged (`lock_release`=0), the LED is off and no table slot holds a valid key, so no strobe can release the lock until a key is enrolled.
- R2: Outside the enrolment window, a `key_stb` whose `key_id` equals a valid slot raises `lock_release` and `led` in the cycle after the strobe.
- R3: While `key_near` stays high after a matching strobe, the lock stays released for any number of ticks.
- R4: Once `key_near` is low, the lock stays released for exactly OPEN_MS ticks of `ms_tick`. In the cycle after the last of those ticks, `lock_release` and `led` both drop to 0.
- R5: A matching strobe during the post-removal hold restarts the hold from the full OPEN_MS ticks.
- R6: Outside the enrolment window, a strobe that matches no valid slot changes nothing: the lock stays engaged and the LED stays off.
- R7: A `learn_btn` pulse while idle enters the enrolment window in the next cycle. The LED is on at entry and then toggles after every BLINK_MS ticks. The lock stays engaged for the whole window, and key strobes never release it.
- R8: In the enrolment window, a strobe writes `key_id` into slot `sel_code` (0 to ENTRIES-1), except when that key is valid in a slot other than `sel_code`. A strobe in the window always ends the window in the next cycle, whether or not it wrote.
- R9: If no key arrives, the enrolment window ends LEARN_MS ticks after entry. The block is then idle and serves matching keys.
- R10: A `learn_btn` pulse during the enrolment window is ignored and does not extend it.
- R11: A `learn_btn` pulse while the lock is released (key present or hold running) abandons the open state. In the next cycle the lock is engaged and the enrolment window is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| key_stb | input | 1 | One-cycle strobe: a key was recognized |
| key_id | input | KEY_W | Identifier of the recognized key, valid with `key_stb` |
| key_near | input | 1 | Level: a key is currently in the reader field |
| learn_btn | input | 1 | One-cycle pulse from the learn button |
| sel_code | input | $clog2(ENTRIES) | Table slot chosen for enrolment |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| lock_release | output | 1 | 1 = lock released |
| led | output | 1 | Indicator LED |

## Verification
A wrong mode register shows up at both outputs one cycle after the stimulus. An open state leaks as a lit LED with the lock released, and a lost enrolment window shows up as a lock that opens on a key it should have enrolled. Timer faults appear exactly at the tick count boundary: a hold that ends one tick early or late, or a restart that fails to extend the hold. These are checked on the tick before and the cycle after expiry. Table faults, such as a dropped duplicate check or a wrong slot, stay hidden until a later strobe. The bench therefore re-presents earlier keys after every enrolment and checks who opens the door.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_OPEN  = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_LEARN = 2'd3
  } mode_e;
endpackage

// File: rtl/keylock_table.sv
module keylock_table #(
  parameter int KEY_W   = 16,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] probe_key,
  input  logic [IDX_W-1:0] slot_sel,
  input  logic             wr_en,
  output logic             hit,
  output logic             dup_other
);
  logic [ENTRIES-1:0] valid_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] slot_we;
  logic [ENTRIES-1:0] sel_oh;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign sel_oh[i]    = (slot_sel == IDX_W'(i));
    assign slot_we[i]   = wr_en && sel_oh[i];
    assign match_vec[i] = valid_q[i] && (key_q[i] == probe_key);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q[i] <= 1'b0;
      else if (slot_we[i]) valid_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (slot_we[i]) key_q[i] <= probe_key;
    end
  end

  always_comb begin
    hit       = |match_vec;
    dup_other = |(match_vec & ~sel_oh);
  end

  // R8
  unique_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(match_vec) <= 1);

  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q != '0) |-> ($past(valid_q) != '0 || $past(wr_en)));
endmodule

// File: rtl/keylock_timer.sv
module keylock_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             stop,
  input  logic             tick,
  output logic             elapsed
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             armed_q, armed_d;

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    if (start) begin
      count_d = load_val;
      armed_d = 1'b1;
    end else begin
      if (tick && count_q != '0) count_d = count_q - 1'b1;
      if (stop || (armed_q && count_q == '0)) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else begin
      count_q <= count_d;
      armed_q <= armed_d;
    end
  end

  assign elapsed = armed_q && (count_q == '0);

  // R4
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !start) |=> (count_q <= $past(count_q)));

  // R9
  single_elapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed && !start) |=> !elapsed);
endmodule

// File: rtl/keylock_blink.sv
module keylock_blink #(
  parameter int BLINK_MS = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic phase
);
  localparam int BW = (BLINK_MS > 1) ? $clog2(BLINK_MS) : 1;

  logic [BW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b1;
    end else if (tick) begin
      if (cnt_q == BW'(BLINK_MS - 1)) begin
        cnt_d   = '0;
        phase_d = ~phase_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

  // R7
  blink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || $stable(phase_q)));
endmodule

// File: rtl/keylock_fsm.sv
module keylock_fsm
  import keylock_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  key_stb,
  input  logic  key_near,
  input  logic  learn_btn,
  input  logic  hit,
  input  logic  dup_other,
  input  logic  elapsed,
  output mode_e mode,
  output logic  tmr_start,
  output logic  tmr_learn,
  output logic  tmr_stop,
  output logic  wr_en
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d    = mode_q;
    tmr_start = 1'b0;
    tmr_learn = 1'b0;
    tmr_stop  = 1'b0;
    wr_en     = 1'b0;
    unique case (mode_q)
      MODE_IDLE: begin
        if (learn_btn) begin
          mode_d    = MODE_LEARN;
          tmr_start = 1'b1;
          tmr_learn = 1'b1;
        end else if (key_stb && hit) begin
          if (key_near) mode_d = MODE_OPEN;
          else begin
            mode_d    = MODE_HOLD;
            tmr_start = 1'b1;
          end
        end
      end
      MODE_OPEN: begin
        if (learn_btn) begin
          mode_d    = MODE_LEARN;
          tmr_start = 1'b1;
          tmr_learn = 1'b1;
        end else if (!key_near) begin
          mode_d    = MODE_HOLD;
          tmr_start = 1'b1;
        end
      end
      MODE_HOLD: begin
        if (learn_btn) begin
          mode_d    = MODE_LEARN;
          tmr_start = 1'b1;
          tmr_learn = 1'b1;
        end else if (key_near) begin
          mode_d   = MODE_OPEN;
          tmr_stop = 1'b1;
        end else if (key_stb && hit) begin
          tmr_start = 1'b1;
        end else if (elapsed) begin
          mode_d = MODE_IDLE;
        end
      end
      MODE_LEARN: begin
        if (key_stb) begin
          wr_en    = !dup_other;
          mode_d   = MODE_IDLE;
          tmr_stop = 1'b1;
        end else if (elapsed) begin
          mode_d = MODE_IDLE;
        end
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R10
  relearn_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LEARN && !key_stb && !elapsed) |=> (mode_q == MODE_LEARN));

  // R8
  learn_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LEARN && key_stb) |=> (mode_q == MODE_IDLE));

  // R11
  learn_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_LEARN && learn_btn) |=> (mode_q == MODE_LEARN));
endmodule

// File: rtl/keylock_ctrl.sv
module keylock_ctrl
  import keylock_pkg::*;
#(
  parameter int KEY_W    = 16,
  parameter int ENTRIES  = 8,
  parameter int OPEN_MS  = 3000,
  parameter int LEARN_MS = 120000,
  parameter int BLINK_MS = 500
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       key_stb,
  input  logic [KEY_W-1:0]           key_id,
  input  logic                       key_near,
  input  logic                       learn_btn,
  input  logic [$clog2(ENTRIES)-1:0] sel_code,
  input  logic                       ms_tick,
  output logic                       lock_release,
  output logic                       led
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int T_MAX = (OPEN_MS > LEARN_MS) ? OPEN_MS : LEARN_MS;
  localparam int CNT_W = $clog2(T_MAX + 1);

  mode_e            mode;
  logic             hit, dup_other, elapsed, phase;
  logic             tmr_start, tmr_learn, tmr_stop, wr_en;
  logic [CNT_W-1:0] load_val;

  keylock_table #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .probe_key (key_id),
    .slot_sel  (sel_code),
    .wr_en     (wr_en),
    .hit       (hit),
    .dup_other (dup_other)
  );

  keylock_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_stb   (key_stb),
    .key_near  (key_near),
    .learn_btn (learn_btn),
    .hit       (hit),
    .dup_other (dup_other),
    .elapsed   (elapsed),
    .mode      (mode),
    .tmr_start (tmr_start),
    .tmr_learn (tmr_learn),
    .tmr_stop  (tmr_stop),
    .wr_en     (wr_en)
  );

  assign load_val = tmr_learn ? CNT_W'(LEARN_MS) : CNT_W'(OPEN_MS);

  keylock_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .load_val (load_val),
    .stop     (tmr_stop),
    .tick     (ms_tick),
    .elapsed  (elapsed)
  );

  keylock_blink #(.BLINK_MS(BLINK_MS)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode == MODE_LEARN),
    .tick  (ms_tick),
    .phase (phase)
  );

  always_comb begin
    lock_release = (mode == MODE_OPEN) || (mode == MODE_HOLD);
    led          = lock_release || ((mode == MODE_LEARN) && phase);
  end

  // R2
  led_follows_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_release |-> led);

  // R7
  learn_keeps_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEARN && !learn_btn) |=> (!lock_release));
endmodule

// File: tb/tb_keylock_ctrl.sv
module tb_keylock_ctrl;
  localparam int KEY_W = 16;
  localparam int ENTRIES = 8;
  localparam int OPEN_MS = 4;
  localparam int LEARN_MS = 10;
  localparam int BLINK_MS = 2;

  logic clk, rst_n, key_stb, key_near, learn_btn, ms_tick;
  logic [KEY_W-1:0] key_id;
  logic [$clog2(ENTRIES)-1:0] sel_code;
  logic lock_release, led;

  typedef struct {
    logic  rel;
    logic  led;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  localparam logic [KEY_W-1:0] KA = 16'h1A2B;
  localparam logic [KEY_W-1:0] KB = 16'h3C4D;
  localparam logic [KEY_W-1:0] KC = 16'h5E6F;

  keylock_ctrl #(.KEY_W(KEY_W), .ENTRIES(ENTRIES), .OPEN_MS(OPEN_MS),
                 .LEARN_MS(LEARN_MS), .BLINK_MS(BLINK_MS)) dut (
    .clk(clk), .rst_n(rst_n), .key_stb(key_stb), .key_id(key_id),
    .key_near(key_near), .learn_btn(learn_btn), .sel_code(sel_code),
    .ms_tick(ms_tick), .lock_release(lock_release), .led(led));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      n_run++;
      if (lock_release !== it.rel || led !== it.led) begin
        n_fail++;
        $display("FAIL %s: release/led actual %b/%b expected %b/%b",
                 it.tag, lock_release, led, it.rel, it.led);
      end
    end
  end

  task automatic expect_out(input logic rel, input logic l, input string tag);
    exp_t it;
    it.rel = rel;
    it.led = l;
    it.tag = tag;
    exp_q.push_back(it);
    #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [KEY_W-1:0] k);
    key_id  = k;
    key_stb = 1'b1;
    @(negedge clk);
    key_stb = 1'b0;
  endtask

  task automatic press_learn(input int slot);
    sel_code  = slot[$clog2(ENTRIES)-1:0];
    learn_btn = 1'b1;
    @(negedge clk);
    learn_btn = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    wait (exp_q.size() == 0);
    #1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; key_stb = 1'b0; key_near = 1'b0; learn_btn = 1'b0;
    ms_tick = 1'b0; key_id = '0; sel_code = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_out(1'b0, 1'b0, "R1 reset state");
    key_near = 1'b1;
    strobe(KA);
    expect_out(1'b0, 1'b0, "R1 empty table refuses key");
    key_near = 1'b0;
    cyc(1);

    // enrolment window and blink
    press_learn(2);
    expect_out(1'b0, 1'b1, "R7 learn entry led on");
    ticks(1);
    expect_out(1'b0, 1'b1, "R7 blink before toggle");
    ticks(1);
    expect_out(1'b0, 1'b0, "R7 blink toggled off");
    ticks(2);
    expect_out(1'b0, 1'b1, "R7 blink toggled on");
    strobe(KA);
    expect_out(1'b0, 1'b0, "R8 enrol ends window");

    // open with key held
    key_near = 1'b1;
    strobe(KA);
    expect_out(1'b1, 1'b1, "R2 valid key opens");
    ticks(20);
    expect_out(1'b1, 1'b1, "R3 held key keeps open");
    key_near = 1'b0;
    cyc(1);
    ticks(3);
    expect_out(1'b1, 1'b1, "R4 hold before expiry");
    ticks(1);
    cyc(1);
    expect_out(1'b0, 1'b0, "R4 relock after hold");

    // restart of hold
    strobe(KA);
    expect_out(1'b1, 1'b1, "R2 strobe without presence opens");
    ticks(3);
    strobe(KA);
    ticks(3);
    expect_out(1'b1, 1'b1, "R5 hold restarted");
    ticks(1);
    cyc(1);
    expect_out(1'b0, 1'b0, "R5 relock after restarted hold");

    // unknown key
    strobe(KC);
    expect_out(1'b0, 1'b0, "R6 unknown key no action");
    ticks(5);
    expect_out(1'b0, 1'b0, "R6 still locked");

    // duplicate rejection
    press_learn(5);
    strobe(KA);
    expect_out(1'b0, 1'b0, "R8 duplicate ends window");
    press_learn(2);
    strobe(KB);
    cyc(1);
    strobe(KA);
    expect_out(1'b0, 1'b0, "R8 duplicate not stored, slot overwritten");
    strobe(KB);
    expect_out(1'b1, 1'b1, "R8 new key at selected slot opens");
    ticks(OPEN_MS);
    cyc(1);
    expect_out(1'b0, 1'b0, "R4 relock");

    // re-press ignored, timeout ends window
    press_learn(4);
    ticks(6);
    press_learn(4);
    ticks(3);
    expect_out(1'b0, 1'b1, "R10 window still running");
    ticks(1);
    cyc(1);
    expect_out(1'b0, 1'b0, "R9 window expired");
    strobe(KB);
    expect_out(1'b1, 1'b1, "R10 re-press did not extend window");
    ticks(OPEN_MS);
    cyc(1);

    // learn abandons open state
    key_near = 1'b1;
    strobe(KB);
    key_near = 1'b0;
    cyc(1);
    ticks(2);
    expect_out(1'b1, 1'b1, "R11 hold running");
    press_learn(3);
    expect_out(1'b0, 1'b1, "R11 learn abandons hold");
    strobe(KC);
    expect_out(1'b0, 1'b0, "R7 strobe in window does not release");
    strobe(KC);
    expect_out(1'b1, 1'b1, "R8 enrolled key opens");
    ticks(OPEN_MS);
    cyc(1);
    expect_out(1'b0, 1'b0, "R4 final relock");

    done = 1;
    finish_run();
  end
endmodule